// File: doc/BRIEF.md
# Three-Operand Register ALU Machine

This block is a small single-issue execution unit. It takes one instruction per clock straight from its input pins. An instruction is a 3-bit operation code, two 4-bit source selectors, a 4-bit destination selector and a 32-bit immediate word. The unit holds a file of sixteen 32-bit registers. It can copy, add, subtract and multiply registers, load a constant, and compare two registers. It can also put any register on its 32-bit result port.

A compare raises a one-cycle jump flag when the two operands are equal. After every compare the unit ignores the next two instructions, so that a surrounding sequencer has time to act on the flag. Code 111 does nothing. Registers, the result port and the flag are cleared by a synchronous active-high reset.

Top module: `alu3_machine`

## Requirements
- R1: While `rst` is high at a rising clock edge, all registers, `result`, `jump` and the penalty count are cleared. After reset, reading any register returns 0.
- R2: Code 101 (load) writes `imm` into the register selected by `dst`.
- R3: Code 000 (move) copies the register selected by `src_a` into the register selected by `dst`. `src_b` has no effect.
- R4: Code 001 (add) writes `src_a + src_b` modulo 2^32 to `dst`.
- R5: Code 010 (subtract) writes `src_a - src_b` modulo 2^32 to `dst`, with `src_a` as the left operand.
- R6: Code 011 (multiply) writes the low 32 bits of `src_a * src_b` to `dst`.
- R7: Code 110 (read) puts the register selected by `src_a` on `result` one clock edge after the instruction is taken. `result` holds its value under every other code.
- R8: Code 100 (compare) writes no register. `jump` is high for exactly the one cycle after the compare edge when the two selected registers are equal, and low otherwise.
- R9: The two clock edges that follow a taken compare accept no instruction. During them no register changes, `result` holds and `jump` is low.
- R10: Code 111 changes no register and no output.
- R11: Operands are read before the edge. An instruction whose destination is also one of its sources uses the old register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| src_a | input | 4 | First source selector (left operand) |
| src_b | input | 4 | Second source selector (right operand) |
| dst | input | 4 | Destination selector |
| imm | input | 32 | Immediate word for load |
| result | output | 32 | Registered read-out port |
| jump | output | 1 | One-cycle equal-compare flag |

## Verification
The hardest thing to observe is the penalty window. Instructions issued during it must leave no trace, and a discarded instruction is invisible at the ports unless it would have changed state that is read later. The stimulus therefore places a load, a read and a second, equal compare inside the window. It then reads the targeted register and watches `jump` to prove that all three were dropped. It also issues a compare of unequal registers to show that the window opens even when `jump` stays low.

// File: rtl/alu3_machine.sv
module alu3_machine #(
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int PENALTY = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] dst,
  input  logic [DW-1:0] imm,
  output logic [DW-1:0] result,
  output logic          jump
);
  localparam int NREG = 1 << AW;
  localparam int PW   = $clog2(PENALTY + 1);

  localparam logic [2:0] OP_MOV = 3'b000;
  localparam logic [2:0] OP_ADD = 3'b001;
  localparam logic [2:0] OP_SUB = 3'b010;
  localparam logic [2:0] OP_MUL = 3'b011;
  localparam logic [2:0] OP_CMP = 3'b100;
  localparam logic [2:0] OP_LDI = 3'b101;
  localparam logic [2:0] OP_RD  = 3'b110;

  logic [DW-1:0] regs [NREG];
  logic [PW-1:0] pen;
  logic [DW-1:0] wdata;
  logic          wr_en;

  wire          idle = (pen == '0);
  wire [DW-1:0] rd_a = regs[src_a];
  wire [DW-1:0] rd_b = regs[src_b];

  always_comb begin
    wr_en = 1'b1;
    wdata = rd_a;
    case (op)
      OP_MOV:  wdata = rd_a;
      OP_ADD:  wdata = rd_a + rd_b;
      OP_SUB:  wdata = rd_a - rd_b;
      OP_MUL:  wdata = rd_a * rd_b;
      OP_LDI:  wdata = imm;
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      pen    <= '0;
      result <= '0;
      jump   <= 1'b0;
    end else begin
      jump <= 1'b0;
      if (!idle) begin
        pen <= pen - 1'b1;
      end else begin
        if (wr_en) regs[dst] <= wdata;
        if (op == OP_RD) result <= rd_a;
        if (op == OP_CMP) begin
          jump <= (rd_a == rd_b);
          pen  <= PW'(PENALTY);
        end
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (result == '0 && !jump && pen == '0));

  a_r7_read_port: assert property (@(posedge clk) disable iff (rst)
    (idle && op == OP_RD) |=> (result == $past(rd_a)));

  a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
    (op != OP_RD) |=> $stable(result));

  a_r8_jump_equal: assert property (@(posedge clk) disable iff (rst)
    (idle && op == OP_CMP && rd_a == rd_b) |=> jump);

  a_r8_jump_single: assert property (@(posedge clk) disable iff (rst)
    jump |=> !jump);

  a_r9_window_opens: assert property (@(posedge clk) disable iff (rst)
    (idle && op == OP_CMP) |=> (pen == PW'(PENALTY)));

  a_r9_window_quiet: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(result) && !jump));

  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    (op == 3'b111) |=> ($stable(result) && !jump));
endmodule

// File: tb/alu3_machine_bench.sv
`timescale 1ns/1ps
module alu3_machine_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [3:0]  src_a, src_b, dst;
  logic [31:0] imm;
  logic [31:0] result;
  logic        jump;

  always #2.5 clk = ~clk;

  alu3_machine u_alu3_machine (
    .clk(clk), .rst(rst), .op(op), .src_a(src_a), .src_b(src_b),
    .dst(dst), .imm(imm), .result(result), .jump(jump)
  );

  typedef struct {
    int          due;
    logic [31:0] dout;
    logic        jmp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] m [16];
  logic [31:0] m_dout;
  int          m_pen;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (result !== it.dout || jump !== it.jmp) begin
        errors++;
        $display("FAIL %s: result=%h jump=%b expected result=%h jump=%b",
                 it.tag, result, jump, it.dout, it.jmp);
      end
    end
  end

  task automatic step(input logic [2:0] o, input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] d, input logic [31:0] k, input string tag);
    item_t it;
    logic  j;
    @(negedge clk);
    op = o; src_a = a; src_b = b; dst = d; imm = k;
    j = 1'b0;
    if (m_pen > 0) begin
      m_pen--;
    end else begin
      case (o)
        3'b000: m[d] = m[a];
        3'b001: m[d] = m[a] + m[b];
        3'b010: m[d] = m[a] - m[b];
        3'b011: m[d] = m[a] * m[b];
        3'b100: begin j = (m[a] == m[b]); m_pen = 2; end
        3'b101: m[d] = k;
        3'b110: m_dout = m[a];
        default: ;
      endcase
    end
    it.due = cyc + 1; it.dout = m_dout; it.jmp = j; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(3'b110, a, 4'd0, 4'd0, 32'd0, tag);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 32'd0;
    m_dout = 32'd0; m_pen = 0;
    rst = 1'b1; op = 3'b111; src_a = 4'd9; src_b = 4'd3; dst = 4'd4; imm = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 32'd0 || jump !== 1'b0) begin
      errors++;
      $display("FAIL R1: result=%h jump=%b expected result=0 jump=0", result, jump);
    end
    rst = 1'b0;
    rd(4'd5, "R1 reg5 after reset");
    rd(4'd15, "R1 reg15 after reset");

    step(3'b101, 4'd0, 4'd0, 4'd0, 32'h51, "R2 load r0");
    step(3'b101, 4'd3, 4'd9, 4'd1, 32'h2, "R2 load r1");
    step(3'b101, 4'd0, 4'd0, 4'd15, 32'hA5A5_0F0F, "R2 load r15");
    step(3'b001, 4'd0, 4'd1, 4'd2, 32'd0, "R4 add");
    step(3'b010, 4'd0, 4'd1, 4'd3, 32'd0, "R5 sub");
    step(3'b011, 4'd0, 4'd1, 4'd4, 32'd0, "R6 mul");
    step(3'b000, 4'd1, 4'd15, 4'd5, 32'h1234, "R3 move ignores src_b");
    step(3'b000, 4'd1, 4'd0, 4'd6, 32'd0, "R3 move");
    rd(4'd0, "R2 read r0"); rd(4'd1, "R2 read r1"); rd(4'd15, "R2 read r15");
    rd(4'd2, "R4 read r2"); rd(4'd3, "R5 read r3"); rd(4'd4, "R6 read r4");
    rd(4'd5, "R3 read r5"); rd(4'd6, "R3 read r6");

    step(3'b100, 4'd5, 4'd6, 4'd7, 32'h77, "R8 compare equal");
    step(3'b101, 4'd0, 4'd0, 4'd7, 32'h99, "R9 load in window");
    step(3'b100, 4'd5, 4'd6, 4'd0, 32'd0, "R9 compare in window");
    rd(4'd7, "R8 R9 r7 untouched");
    step(3'b100, 4'd0, 4'd1, 4'd0, 32'd0, "R8 compare unequal");
    rd(4'd0, "R9 read in window");
    step(3'b111, 4'd2, 4'd2, 4'd2, 32'd0, "R9 nop in window");
    rd(4'd0, "R9 window closed");

    step(3'b101, 4'd0, 4'd0, 4'd8, 32'hFFFF_FFFF, "R2 load all ones");
    step(3'b001, 4'd8, 4'd1, 4'd9, 32'd0, "R4 add wraps");
    step(3'b010, 4'd1, 4'd0, 4'd10, 32'd0, "R5 sub borrow wraps");
    step(3'b010, 4'd1, 4'd8, 4'd11, 32'd0, "R5 sub order");
    step(3'b011, 4'd8, 4'd8, 4'd12, 32'd0, "R6 mul low bits");
    step(3'b101, 4'd0, 4'd0, 4'd13, 32'h1234_5678, "R2 load");
    step(3'b011, 4'd13, 4'd13, 4'd14, 32'd0, "R6 mul truncate");
    rd(4'd9, "R4 read r9"); rd(4'd10, "R5 read r10");
    rd(4'd11, "R5 read r11"); rd(4'd12, "R6 read r12"); rd(4'd14, "R6 read r14");

    step(3'b111, 4'd0, 4'd1, 4'd0, 32'hFFFF_FFFF, "R10 nop");
    step(3'b111, 4'd1, 4'd1, 4'd13, 32'd7, "R10 nop");
    rd(4'd0, "R10 r0 kept"); rd(4'd13, "R10 r13 kept");

    step(3'b001, 4'd2, 4'd2, 4'd2, 32'd0, "R11 add self");
    step(3'b010, 4'd3, 4'd1, 4'd1, 32'd0, "R11 sub into source");
    step(3'b011, 4'd13, 4'd14, 4'd13, 32'd0, "R11 mul into source");
    rd(4'd2, "R11 read r2"); rd(4'd1, "R11 read r1"); rd(4'd13, "R11 read r13");
    step(3'b100, 4'd8, 4'd8, 4'd0, 32'd0, "R8 compare same reg");
    step(3'b111, 4'd0, 4'd0, 4'd0, 32'd0, "R9 window");
    step(3'b111, 4'd0, 4'd0, 4'd0, 32'd0, "R9 window");
    rd(4'd8, "R8 compare writes nothing");

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule